// File: doc/BRIEF.md
# Flash Program/Erase Status Word Generator

This block builds the 8-bit status word that a flash array controller returns on bus reads while an embedded program or erase runs. It also covers reads of blocks that are being erased while that erase is suspended. The controller supplies the operation kind, the target bit 7 of a program, whether a multi-block erase has left its block-collection window, the suspend state, and error events. It also supplies the read strobe, the block index of the read address, and two per-block bitmaps: blocks selected for erase and blocks that failed to erase.

The status word carries a polling bit, a global toggle bit, a sticky error bit, an erase-started indicator and a block-sensitive toggle bit. Software can use that last bit to locate failing blocks. A companion output tells the read path whether the current read returns status or normal array data. The array data path itself is outside this block.

Top module: `flash_status_gen`

## Requirements
- R1: After reset (rst_n low), status is 8'h00, both toggle bits are 0 and the error bit is 0.
- R2: Operation kinds are op_kind 1 = program, 2 = chip erase, 3 = block erase, 0 = none. Status bit 7 is the inverse of prog_bit7 during a program. It is 0 during an erase and 1 whenever suspended is high.
- R3: Status bit 6 inverts on the clock after each rd_stb while status_sel is high and suspended is low. It holds its value while suspended.
- R4: Status bit 5 is set on the clock after fail_pulse and stays 1 until the clock after clear_cmd. clear_cmd wins when both are high.
- R5: Status bit 3 is 1 during a chip erase and equals erase_started during a block erase. It is 0 otherwise.
- R6: With the error bit clear and a block erase running, status bit 2 inverts on the clock after an rd_stb whose rd_blk has its bit set in erase_map. Reads of other blocks leave it unchanged.
- R7: With the error bit set during an erase, bit 2 inverts only on reads whose block has its bit set in fault_map. Reads of blocks that erased correctly leave it unchanged.
- R8: status_sel is 1 while op_active is high and suspended is low. While suspended, it is 1 only for reads of a block whose erase_map bit is set, so reads of non-erasing blocks return array data.
- R9: Status bits 4, 1 and 0 are always 0.
- R10: op_start clears both toggle bits on the next clock, taking priority over a simultaneous rd_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Pulse at the start of each program or erase |
| op_active | input | 1 | An operation is in progress or its error is pending |
| op_kind | input | 2 | 1 program, 2 chip erase, 3 block erase, 0 none |
| prog_bit7 | input | 1 | Bit 7 of the data being programmed |
| erase_started | input | 1 | Block erase has left its block-collection window |
| suspended | input | 1 | Erase is suspended |
| fail_pulse | input | 1 | Controller detected a program or erase failure |
| clear_cmd | input | 1 | Reset command decoded; clears the error bit |
| rd_stb | input | 1 | One-cycle strobe per bus read |
| rd_blk | input | BLK_W | Block index of the read address |
| erase_map | input | NUM_BLOCKS | Blocks selected for erase |
| fault_map | input | NUM_BLOCKS | Blocks that failed to erase |
| status | output | 8 | Status word |
| status_sel | output | 1 | Current read returns status rather than array data |

## Verification
The bench targets two error modes of bit 2. One is a bit 2 that flips on reads of non-erasing blocks, which would show up as a toggle on a read the model leaves steady. The other is a bit 2 that keeps following the erase map after an error, so healthy blocks appear to fail. The bench also suspends mid-erase to catch bit 6 still toggling, bit 7 staying 0, and status being returned on non-erasing reads. Other stimuli overlap op_start with a read strobe and clear_cmd with fail_pulse, which exposes wrong priorities as stale toggles or a lingering error bit.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int NUM_BLOCKS = 35,
  parameter int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_start,
  input  logic                  op_active,
  input  logic [1:0]            op_kind,
  input  logic                  prog_bit7,
  input  logic                  erase_started,
  input  logic                  suspended,
  input  logic                  fail_pulse,
  input  logic                  clear_cmd,
  input  logic                  rd_stb,
  input  logic [BLK_W-1:0]      rd_blk,
  input  logic [NUM_BLOCKS-1:0] erase_map,
  input  logic [NUM_BLOCKS-1:0] fault_map,
  output logic [7:0]            status,
  output logic                  status_sel
);
  localparam int SPAN = 1 << BLK_W;
  localparam logic [1:0] K_PROG = 2'd1, K_CHIP = 2'd2, K_BLK = 2'd3;

  logic [SPAN-1:0] erase_ext, fault_ext;
  logic tog_all, tog_blk, err_q;
  logic is_prog, is_erase, hit_erase, hit_fault, blk_sel;

  assign erase_ext = SPAN'(erase_map);
  assign fault_ext = SPAN'(fault_map);
  assign hit_erase = erase_ext[rd_blk];
  assign hit_fault = fault_ext[rd_blk];
  assign is_prog   = op_kind == K_PROG;
  assign is_erase  = op_kind == K_CHIP || op_kind == K_BLK;
  assign blk_sel   = is_erase && (err_q ? hit_fault : hit_erase);

  assign status_sel = op_active && (!suspended || hit_erase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_all <= 1'b0;
      tog_blk <= 1'b0;
    end else if (op_start) begin
      tog_all <= 1'b0;
      tog_blk <= 1'b0;
    end else if (rd_stb && status_sel) begin
      if (!suspended) tog_all <= ~tog_all;
      if (blk_sel)    tog_blk <= ~tog_blk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (clear_cmd)  err_q <= 1'b0;
    else if (fail_pulse) err_q <= 1'b1;
  end

  always_comb begin
    status    = 8'h00;
    status[7] = suspended ? 1'b1 : (is_prog ? ~prog_bit7 : 1'b0);
    status[6] = tog_all;
    status[5] = err_q;
    status[3] = (op_kind == K_CHIP) || (op_kind == K_BLK && erase_started);
    status[2] = tog_blk;
  end
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk #(
  parameter int NUM_BLOCKS = 35,
  parameter int BLK_W = $clog2(NUM_BLOCKS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  op_start,
  input logic                  op_active,
  input logic [1:0]            op_kind,
  input logic                  prog_bit7,
  input logic                  suspended,
  input logic                  fail_pulse,
  input logic                  clear_cmd,
  input logic [BLK_W-1:0]      rd_blk,
  input logic [NUM_BLOCKS-1:0] erase_map,
  input logic [7:0]            status,
  input logic                  status_sel
);
  localparam int SPAN = 1 << BLK_W;
  logic [SPAN-1:0] emap;
  assign emap = SPAN'(erase_map);

  p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] == 1'b0 && status[1] == 1'b0 && status[0] == 1'b0);

  p_prog_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == 2'd1 && !suspended) |-> status[7] == !prog_bit7);

  p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_pulse && !clear_cmd) |=> status[5]);

  p_err_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !clear_cmd) |=> status[5]);

  p_susp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !op_start) |=> $stable(status[6]));

  p_susp_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !emap[rd_blk]) |-> !status_sel);

  p_start_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> (!status[6] && !status[2]));
endmodule

bind flash_status_gen flash_status_gen_chk #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_active(op_active),
  .op_kind(op_kind), .prog_bit7(prog_bit7), .suspended(suspended),
  .fail_pulse(fail_pulse), .clear_cmd(clear_cmd), .rd_blk(rd_blk),
  .erase_map(erase_map), .status(status), .status_sel(status_sel)
);

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
  localparam int NB = 35;
  localparam int BW = $clog2(NB);

  logic clk = 0, rst_n = 0;
  logic op_start = 0, op_active = 0, prog_bit7 = 0, erase_started = 0;
  logic suspended = 0, fail_pulse = 0, clear_cmd = 0, rd_stb = 0;
  logic [1:0] op_kind = 0;
  logic [BW-1:0] rd_blk = 0;
  logic [NB-1:0] erase_map = 0, fault_map = 0;
  logic [7:0] status;
  logic status_sel;

  int checks = 0, fails = 0;
  bit m_t6 = 0, m_t2 = 0, m_err = 0;
  bit done = 0;

  flash_status_gen #(.NUM_BLOCKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_active(op_active),
    .op_kind(op_kind), .prog_bit7(prog_bit7), .erase_started(erase_started),
    .suspended(suspended), .fail_pulse(fail_pulse), .clear_cmd(clear_cmd),
    .rd_stb(rd_stb), .rd_blk(rd_blk), .erase_map(erase_map),
    .fault_map(fault_map), .status(status), .status_sel(status_sel));

  always #5 clk = ~clk;

  function automatic bit in_map(logic [NB-1:0] m, int idx);
    return (idx < NB) ? m[idx] : 1'b0;
  endfunction

  function automatic bit exp_sel();
    return op_active && (!suspended || in_map(erase_map, int'(rd_blk)));
  endfunction

  // reference model: next state sampled on the clock edge
  always @(posedge clk) begin
    bit erasing, hit;
    erasing = (op_kind == 2'd2 || op_kind == 2'd3);
    hit = m_err ? in_map(fault_map, int'(rd_blk)) : in_map(erase_map, int'(rd_blk));
    if (!rst_n) begin
      m_t6 = 0; m_t2 = 0; m_err = 0;
    end else begin
      if (op_start) begin
        m_t6 = 0; m_t2 = 0;
      end else if (rd_stb && exp_sel()) begin
        if (!suspended) m_t6 = !m_t6;
        if (erasing && hit) m_t2 = !m_t2;
      end
      if (clear_cmd) m_err = 0;
      else if (fail_pulse) m_err = 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    bit e7, e3;
    e7 = suspended ? 1'b1 : (op_kind == 2'd1 ? !prog_bit7 : 1'b0);
    e3 = (op_kind == 2'd2) || (op_kind == 2'd3 && erase_started);
    if (!rst_n) chk("R1 reset", int'(status), 0);
    else begin
      chk("R2 bit7", int'(status[7]), int'(e7));
      chk("R3 bit6", int'(status[6]), int'(m_t6));
      chk("R4 bit5", int'(status[5]), int'(m_err));
      chk("R5 bit3", int'(status[3]), int'(e3));
      chk("R6 R7 R10 bit2", int'(status[2]), int'(m_t2));
      chk("R8 status_sel", int'(status_sel), int'(exp_sel()));
      chk("R9 reserved bits", int'({status[4], status[1], status[0]}), 0);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic rd(int blk);
    rd_blk = BW'(blk); rd_stb = 1; step(); rd_stb = 0; step();
  endtask

  task automatic start(logic [1:0] k);
    op_kind = k; op_active = 1; op_start = 1; step(); op_start = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1; step();
    // program
    prog_bit7 = 1; start(2'd1);
    rd(0); rd(7); rd(34);
    prog_bit7 = 0; rd(2);
    fail_pulse = 1; step(); fail_pulse = 0; rd(4);
    clear_cmd = 1; fail_pulse = 1; step(); clear_cmd = 0; fail_pulse = 0; step();
    op_active = 0; op_kind = 0; step();
    // block erase on blocks 3 and 5
    erase_map = '0; erase_map[3] = 1; erase_map[5] = 1;
    start(2'd3);
    rd(3); rd(9); rd(5);
    erase_started = 1; rd(3); rd(10);
    suspended = 1; rd(3); rd(11); rd(5); rd(12);
    suspended = 0; rd(5);
    // error: only block 5 failed
    fault_map[5] = 1; fail_pulse = 1; step(); fail_pulse = 0;
    rd(3); rd(5); rd(3); rd(5); rd(20);
    // op_start overlapping a read
    rd_blk = BW'(5); rd_stb = 1; op_start = 1; step(); rd_stb = 0; op_start = 0; step();
    clear_cmd = 1; step(); clear_cmd = 0;
    erase_started = 0; fault_map = 0; op_active = 0; op_kind = 0; step();
    // chip erase
    erase_map = '1; start(2'd2); rd(0); rd(33); rd(17);
    op_active = 0; op_kind = 0; step();
    // random traffic
    for (int i = 0; i < 2000; i++) begin
      op_start = ($urandom % 40) == 0;
      op_active = ($urandom % 8) != 0;
      op_kind = 2'($urandom);
      prog_bit7 = 1'($urandom);
      erase_started = 1'($urandom);
      suspended = ($urandom % 4) == 0;
      fail_pulse = ($urandom % 30) == 0;
      clear_cmd = ($urandom % 30) == 0;
      rd_stb = 1'($urandom);
      rd_blk = BW'($urandom % 40);
      erase_map = NB'({$urandom, $urandom});
      fault_map = NB'({$urandom, $urandom});
      step();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule